// File: doc/BRIEF.md
# Reuse-Distance Block Placement Classifier

This block watches a stream of accesses to a fixed set of on-chip data blocks. For each block it measures how many other accesses fell between its two latest accesses, and it takes that gap as the forecast of how soon the block will be needed again. When the use of a block ends, the surrounding memory manager pulses a done strobe. The classifier then chooses one of three homes for the block: kept on-chip in raw form, kept on-chip compressed, or compressed and moved off-chip. Two programmable thresholds set the boundaries between the three tiers.

Before a block goes into an on-chip tier that reports no free room, the classifier scans the whole block table once. It picks the resident block whose forecast next use is farthest away and commands its eviction. It then checks the room again and repeats the scan until the tier has space. Commands leave one at a time on a valid/ready handshake. The compression engine and the data movers carry them out and report tier occupancy back as two full flags.

Top module: `rdc_placer`

## Requirements
- R1: After reset, `busy` and `cmdValid` are low and no block has any access history.
- R2: Accesses are counted in order. The gap of a block is the number of accesses to other blocks between its two latest accesses, and its forecast distance Tn is that gap.
- R3: For a done block, Tn <= th1 gives op 0 (keep raw), th1 < Tn <= th2 gives op 1 (keep compressed), and Tn > th2 gives op 2 (evict) for that block itself, with no capacity check.
- R4: A block accessed only once since reset has Tn = 2^STAMP_W-1.
- R5: When the chosen tier is not full, the placement command for a done strobe sampled on rising edge k is valid from edge k+1, with `cmdId` equal to the done block.
- R6: When the chosen on-chip tier is full, the classifier scans N_BLOCKS cycles. It then issues op 2 for the resident block other than the done block that has the largest Tn, choosing the lowest ID on a tie. The command is valid from edge k+1+N_BLOCKS.
- R7: A victim command accepted on edge m is followed by a fresh capacity check on edge m+1. That check leads either to another scan or to the placement command.
- R8: If a full tier has no eviction candidate, the placement command is issued anyway, valid from edge k+2+N_BLOCKS.
- R9: While `cmdValid` is high and `cmdReady` is low, `cmdValid`, `cmdOp` and `cmdId` hold steady. Exactly one command is consumed per handshake.
- R10: A done strobe that arrives while `busy` is high is ignored and produces no command.
- R11: An accepted op 2 removes the named block from the eviction candidates. An access puts the block back on-chip as a candidate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Block access event |
| accId | input | ID_W | Block accessed |
| doneValid | input | 1 | Use of a block has completed |
| doneId | input | ID_W | Block whose use completed |
| th1 | input | STAMP_W | Raw/compressed threshold |
| th2 | input | STAMP_W | Compressed/off-chip threshold |
| rawFull | input | 1 | Raw on-chip tier has no room |
| cmpFull | input | 1 | Compressed on-chip tier has no room |
| cmdValid | output | 1 | Command present |
| cmdReady | input | 1 | Command taken this cycle |
| cmdOp | output | 2 | 0 keep raw, 1 keep compressed, 2 evict |
| cmdId | output | ID_W | Block the command names |
| busy | output | 1 | A classification is in progress |

## Verification
A placement command is due one edge after the edge that samples the done strobe. A victim command is due N_BLOCKS edges after that, and a placement with no eligible victim one edge later still. After each accepted victim, the next result is due counting again from the edge after acceptance. The bench drives on falling edges, waits exactly that many falling edges and checks that the command is absent before the due point and present with the forecast op and ID at it. Tier fullness comes from a bench counter of evictions still needed. Expected gaps, tiers and victims come from a bench model of the access history.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
  typedef enum logic [1:0] {
    OP_RAW   = 2'd0,
    OP_CMP   = 2'd1,
    OP_EVICT = 2'd2
  } placeOp_t;

  typedef struct packed {
    logic latchCur;
    logic scanStart;
    logic scanStep;
    logic applyCmd;
  } ctlStrb_t;
endpackage

// File: rtl/rdc_table.sv
module rdc_table
  import rdc_pkg::*;
#(
  parameter int N_BLOCKS = 8,
  parameter int STAMP_W  = 8,
  parameter int ID_W     = $clog2(N_BLOCKS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accValid,
  input  logic [ID_W-1:0]    accId,
  input  logic [ID_W-1:0]    doneId,
  input  logic [STAMP_W-1:0] th1,
  input  logic [STAMP_W-1:0] th2,
  input  ctlStrb_t           strb,
  input  placeOp_t           cmdOp,
  input  logic [ID_W-1:0]    cmdId,
  output logic [ID_W-1:0]    curId,
  output placeOp_t           curTier,
  output logic               scanLast,
  output logic               victimFound,
  output logic [ID_W-1:0]    victimId
);
  localparam logic [ID_W-1:0] LAST_IDX = ID_W'(N_BLOCKS - 1);

  logic [N_BLOCKS-1:0] seen, hasGap, onChip;
  logic [STAMP_W-1:0]  stamp [N_BLOCKS];
  logic [STAMP_W-1:0]  gap   [N_BLOCKS];
  logic [STAMP_W-1:0]  tnOf  [N_BLOCKS];
  logic [STAMP_W-1:0]  accCnt;
  logic [STAMP_W-1:0]  victimTn, tnCur;
  logic [ID_W-1:0]     scanIdx;

  for (genvar i = 0; i < N_BLOCKS; i++) begin : g_tn
    assign tnOf[i] = hasGap[i] ? gap[i] : '1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen   <= '0;
      hasGap <= '0;
      onChip <= '0;
      accCnt <= '0;
      for (int i = 0; i < N_BLOCKS; i++) begin
        stamp[i] <= '0;
        gap[i]   <= '0;
      end
    end else begin
      if (strb.applyCmd) onChip[cmdId] <= (cmdOp != OP_EVICT);
      if (accValid) begin
        if (seen[accId]) begin
          gap[accId]    <= accCnt - stamp[accId] - STAMP_W'(1);
          hasGap[accId] <= 1'b1;
        end
        stamp[accId]  <= accCnt;
        seen[accId]   <= 1'b1;
        onChip[accId] <= 1'b1;
        accCnt        <= accCnt + STAMP_W'(1);
      end
    end
  end

  assign tnCur = tnOf[curId];
  always_comb begin
    if (tnCur <= th1)      curTier = OP_RAW;
    else if (tnCur <= th2) curTier = OP_CMP;
    else                   curTier = OP_EVICT;
  end

  assign scanLast = (scanIdx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curId       <= '0;
      scanIdx     <= '0;
      victimFound <= 1'b0;
      victimId    <= '0;
      victimTn    <= '0;
    end else begin
      if (strb.latchCur) begin
        curId       <= doneId;
        victimFound <= 1'b0;
      end
      if (strb.scanStart) begin
        scanIdx     <= '0;
        victimFound <= 1'b0;
      end else if (strb.scanStep) begin
        if (onChip[scanIdx] && scanIdx != curId &&
            (!victimFound || tnOf[scanIdx] > victimTn)) begin
          victimFound <= 1'b1;
          victimId    <= scanIdx;
          victimTn    <= tnOf[scanIdx];
        end
        scanIdx <= scanIdx + ID_W'(1);
      end
    end
  end

  AST_NO_SELF_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
    victimFound |-> victimId != curId); // R6
  AST_HIST_NEEDS_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (hasGap & ~seen) == '0); // R4
  AST_ACC_ONCHIP: assert property (@(posedge clk) disable iff (!rst_n)
    accValid |=> onChip[$past(accId)]); // R11
endmodule

// File: rtl/rdc_ctrl.sv
module rdc_ctrl
  import rdc_pkg::*;
#(
  parameter int ID_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            doneValid,
  input  logic            rawFull,
  input  logic            cmpFull,
  input  placeOp_t        curTier,
  input  logic            scanLast,
  input  logic            victimFound,
  input  logic [ID_W-1:0] victimId,
  input  logic [ID_W-1:0] curId,
  input  logic            cmdReady,
  output ctlStrb_t        strb,
  output logic            cmdValid,
  output placeOp_t        cmdOp,
  output logic [ID_W-1:0] cmdId,
  output logic            busy
);
  typedef enum logic [2:0] {S_IDLE, S_CLASSIFY, S_SCAN, S_VICTIM, S_PLACE} state_t;
  state_t   state, nextState;
  placeOp_t opReg;
  logic     tierFull;

  assign tierFull = (curTier == OP_RAW) ? rawFull : cmpFull;

  always_comb begin
    strb      = '0;
    nextState = state;
    unique case (state)
      S_IDLE: if (doneValid) begin
        strb.latchCur = 1'b1;
        nextState     = S_CLASSIFY;
      end
      S_CLASSIFY: begin
        if (curTier != OP_EVICT && tierFull) begin
          strb.scanStart = 1'b1;
          nextState      = S_SCAN;
        end else begin
          nextState = S_PLACE;
        end
      end
      S_SCAN: begin
        strb.scanStep = 1'b1;
        if (scanLast) nextState = S_VICTIM;
      end
      S_VICTIM: begin
        if (!victimFound) nextState = S_PLACE;
        else if (cmdReady) begin
          strb.applyCmd = 1'b1;
          nextState     = S_CLASSIFY;
        end
      end
      S_PLACE: if (cmdReady) begin
        strb.applyCmd = 1'b1;
        nextState     = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      opReg <= OP_RAW;
    end else begin
      state <= nextState;
      if (state == S_CLASSIFY) opReg <= curTier;
    end
  end

  assign cmdValid = (state == S_PLACE) || (state == S_VICTIM && victimFound);
  assign cmdOp    = (state == S_VICTIM) ? OP_EVICT : opReg;
  assign cmdId    = (state == S_VICTIM) ? victimId : curId;
  assign busy     = (state != S_IDLE);

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdOp) && $stable(cmdId)); // R9
  AST_CMD_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid |-> busy); // R10
  AST_DONE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid && !busy |=> busy && !cmdValid); // R5
  AST_OP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid |-> cmdOp != 2'd3); // R3
endmodule

// File: rtl/rdc_placer.sv
module rdc_placer
  import rdc_pkg::*;
#(
  parameter int N_BLOCKS = 8,
  parameter int STAMP_W  = 8,
  parameter int ID_W     = $clog2(N_BLOCKS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accValid,
  input  logic [ID_W-1:0]    accId,
  input  logic               doneValid,
  input  logic [ID_W-1:0]    doneId,
  input  logic [STAMP_W-1:0] th1,
  input  logic [STAMP_W-1:0] th2,
  input  logic               rawFull,
  input  logic               cmpFull,
  output logic               cmdValid,
  input  logic               cmdReady,
  output logic [1:0]         cmdOp,
  output logic [ID_W-1:0]    cmdId,
  output logic               busy
);
  ctlStrb_t        strb;
  placeOp_t        curTier, opW;
  logic [ID_W-1:0] curId, victimId;
  logic            scanLast, victimFound;

  rdc_table #(.N_BLOCKS(N_BLOCKS), .STAMP_W(STAMP_W), .ID_W(ID_W)) u_table (
    .clk(clk), .rst_n(rst_n), .accValid(accValid), .accId(accId),
    .doneId(doneId), .th1(th1), .th2(th2), .strb(strb),
    .cmdOp(opW), .cmdId(cmdId), .curId(curId), .curTier(curTier),
    .scanLast(scanLast), .victimFound(victimFound), .victimId(victimId)
  );

  rdc_ctrl #(.ID_W(ID_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .doneValid(doneValid), .rawFull(rawFull),
    .cmpFull(cmpFull), .curTier(curTier), .scanLast(scanLast),
    .victimFound(victimFound), .victimId(victimId), .curId(curId),
    .cmdReady(cmdReady), .strb(strb), .cmdValid(cmdValid), .cmdOp(opW),
    .cmdId(cmdId), .busy(busy)
  );

  assign cmdOp = opW;
endmodule

// File: tb/rdc_placer_tb.sv
module rdc_placer_tb;
  localparam int N  = 8;
  localparam int SW = 8;
  localparam int IW = 3;

  logic clk = 0, rst_n = 0;
  logic accValid = 0, doneValid = 0, cmdReady = 1;
  logic [IW-1:0] accId = 0, doneId = 0;
  logic [SW-1:0] th1 = 2, th2 = 5;
  logic rawFull, cmpFull;
  logic cmdValid, busy;
  logic [1:0] cmdOp;
  logic [IW-1:0] cmdId;

  int checks = 0, errors = 0, cyc = 0;
  int rawLeft = 0, cmpLeft = 0;
  int mSeen[N], mHas[N], mStamp[N], mGap[N], mOn[N];
  int mCnt;

  assign rawFull = (rawLeft > 0);
  assign cmpFull = (cmpLeft > 0);

  always #5 clk = ~clk;

  rdc_placer #(.N_BLOCKS(N), .STAMP_W(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .accValid(accValid), .accId(accId),
    .doneValid(doneValid), .doneId(doneId), .th1(th1), .th2(th2),
    .rawFull(rawFull), .cmpFull(cmpFull), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .cmdOp(cmdOp), .cmdId(cmdId), .busy(busy)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int tnOf(input int i);
    return mHas[i] ? mGap[i] : (1 << SW) - 1;
  endfunction

  function automatic int tierOf(input int tn);
    if (tn <= int'(th1)) return 0;
    if (tn <= int'(th2)) return 1;
    return 2;
  endfunction

  task automatic doReset();
    rst_n = 0;
    for (int i = 0; i < N; i++) begin
      mSeen[i] = 0; mHas[i] = 0; mStamp[i] = 0; mGap[i] = 0; mOn[i] = 0;
    end
    mCnt = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic access(input int id);
    accValid = 1; accId = IW'(id);
    @(posedge clk);
    if (mSeen[id] != 0) begin
      mGap[id] = (mCnt - mStamp[id] - 1) & ((1 << SW) - 1);
      mHas[id] = 1;
    end
    mStamp[id] = mCnt; mSeen[id] = 1; mOn[id] = 1;
    mCnt = (mCnt + 1) & ((1 << SW) - 1);
    @(negedge clk);
    accValid = 0;
  endtask

  task automatic doDone(input int id, input bit hold, input string req);
    int exp, v, bestTn, waitN;
    bit full;
    exp = tierOf(tnOf(id));
    doneValid = 1; doneId = IW'(id);
    @(posedge clk);
    @(negedge clk);
    doneValid = 0;
    chk(busy && !cmdValid, "R5 busy without early command", int'(cmdValid), 0);
    waitN = 1;
    forever begin
      full = (exp == 0) ? (rawLeft > 0) : (exp == 1) ? (cmpLeft > 0) : 1'b0;
      if (!full) begin waitN = 1; break; end
      v = -1; bestTn = -1;
      for (int i = 0; i < N; i++)
        if (mOn[i] != 0 && i != id && tnOf(i) > bestTn) begin v = i; bestTn = tnOf(i); end
      if (v < 0) begin waitN = N + 2; break; end
      repeat (N) begin
        @(negedge clk);
        chk(!cmdValid, "R6 no command during scan", int'(cmdValid), 0);
      end
      @(negedge clk);
      chk(cmdValid && cmdOp == 2'd2, "R6 victim evict op", int'(cmdOp), 2);
      chk(cmdId == IW'(v), "R6 R11 victim id", int'(cmdId), v);
      @(posedge clk);
      mOn[v] = 0;
      @(negedge clk);
      if (exp == 0) rawLeft--; else cmpLeft--;
      chk(!cmdValid && busy, "R7 recheck cycle", int'(cmdValid), 0);
    end
    repeat (waitN - 1) begin
      @(negedge clk);
      chk(!cmdValid, "R8 no early placement", int'(cmdValid), 0);
    end
    @(negedge clk);
    chk(cmdValid && cmdOp == 2'(exp), {req, " placement op"}, int'(cmdOp), exp);
    chk(cmdId == IW'(id), {req, " placement id"}, int'(cmdId), id);
    if (hold) begin
      cmdReady = 0;
      doneValid = 1; doneId = IW'((id + 1) % N);
      repeat (3) begin
        @(negedge clk);
        doneValid = 0;
        chk(cmdValid && cmdOp == 2'(exp) && cmdId == IW'(id), "R9 held command",
            int'(cmdId), id);
      end
      cmdReady = 1;
    end
    @(posedge clk);
    mOn[id] = (exp != 2);
    @(negedge clk);
    chk(!busy && !cmdValid, "R9 one command per handshake", int'(busy), 0);
    if (hold) begin
      repeat (3) begin
        @(negedge clk);
        chk(!cmdValid && !busy, "R10 done while busy ignored", int'(cmdValid), 0);
      end
    end
  endtask

  initial begin
    doReset();
    chk(!busy, "R1 busy after reset", int'(busy), 0);
    chk(!cmdValid, "R1 cmdValid after reset", int'(cmdValid), 0);

    // R4: single access gives maximum distance, beyond th2 = 5
    access(7);
    doDone(7, 0, "R4 fresh block off-chip");

    // R2 R3: gap sweep across both thresholds
    for (int g = 0; g < 8; g++) begin
      access(0);
      for (int j = 0; j < g; j++) access(1 + (j % 6));
      access(0);
      doDone(0, 0, "R2 R3 gap sweep");
    end

    // R4: maximum distance inside th2 gives compressed
    th2 = 8'd255;
    access(6);
    doDone(6, 0, "R4 fresh block compressed");
    th2 = 8'd5;

    // R6 R7: raw tier full for one eviction, then two
    access(3); access(3);
    rawLeft = 1;
    doDone(3, 0, "R6 raw after one victim");
    access(3); access(3);
    rawLeft = 2;
    doDone(3, 0, "R7 raw after two victims");

    // R6: compressed tier full
    access(2); access(1); access(4); access(5); access(6); access(2);
    cmpLeft = 1;
    doDone(2, 0, "R6 compressed after victim");

    // R9 R10: stalled command and ignored strobe
    access(3); access(3);
    doDone(3, 1, "R9 stalled placement");

    // R8: full tier with no candidate
    doReset();
    access(2); access(2);
    rawLeft = 1;
    doDone(2, 0, "R8 no candidate");
    rawLeft = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule